// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Component Writes

This block is a 256-entry colour lookup table for a display pipeline. Software sees a small register window of four 32-bit slots. One slot selects which entry is being programmed and the next slot accepts colour components for that entry. Every byte that matters is carried in the top byte of the 32-bit write. The lower bytes are discarded.

Components arrive as a fixed sequence of red, then green, then blue. After the blue component lands, the selected entry steps forward by one, so a whole table can be loaded with one index write followed by a stream of data writes. The pixel side has an independent lookup port. It is combinational, so a scan-out pipeline can present one 8-bit pixel code per cycle and get the 24-bit colour back in the same cycle.

Reset sets every entry to black except the last one, which becomes white. The bus is write-only in effect, because reads always return zero. The interface is a plain one-cycle-per-transfer write strobe. The lookup port has no handshake and never stalls.

Top module: `clut_dac`

## Requirements
- R1: After synchronous reset, lookup of codes 0 to 254 returns 24'h000000 and lookup of code 255 returns 24'hFFFFFF.
- R2: The slot is chosen by addr[3:2] alone: 0 is the index slot, 1 the component slot, 2 and 3 spare. addr[1:0] has no effect.
- R3: A write to the index slot loads the current entry from wdata[31:24] and restarts the component sequence at red, even in the middle of a sequence.
- R4: Writes to the component slot take wdata[31:24] and store it in turn as red, green and then blue of the current entry; wdata[23:0] is ignored. The lookup result packs red in bits [23:16], green in [15:8] and blue in [7:0].
- R5: The write that stores blue advances the current entry by one modulo 256 (255 wraps to 0), and the next component write is red again.
- R6: Writes to the spare slots change neither the table, the current entry nor the position in the component sequence.
- R7: rdata is zero at all times.
- R8: lookup_rgb follows lookup_code within the same cycle with no clock edge in between. A stored component is visible from the cycle after its write edge.
- R9: While wr_en is low, addr and wdata have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one transfer per cycle |
| addr | input | 4 | Byte address within the 16-byte register window |
| wdata | input | 32 | Write data; only bits [31:24] are used |
| rdata | output | 32 | Read data, always zero |
| lookup_code | input | 8 | Pixel code to translate |
| lookup_rgb | output | 24 | Colour for lookup_code, {red, green, blue} |

## Verification
The current-entry register and the component phase cannot be seen directly. A wrong value in either shows up only when the next component write lands in the wrong entry or the wrong channel, and lookup_rgb exposes that one cycle after the write edge. The bench keeps a behavioural model of all three channel arrays. Every cycle it compares the colour for whatever code is applied, and it reads back the entries next to each written one. This catches misplaced writes as well as missing ones. Sequences that are cut short by an index write or interleaved with spare-slot writes are used so that a phase that drifts by one step shows up as a swapped channel.

// File: rtl/clut_pkg.sv
`timescale 1ns/100ps
package clut_pkg;
  localparam int WIN_ADDR_W = 4;
  localparam int SEL_LSB    = 2;
  localparam int NCH        = 3;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_SPARE_A = 2'd2,
    SEL_SPARE_B = 2'd3
  } regsel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/clut_decode.sv
`timescale 1ns/100ps
module clut_decode
  import clut_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic                  wr_en,
  input  logic [WIN_ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]      wdata,
  output logic                  idx_wr,
  output logic                  data_wr,
  output logic [IDX_W-1:0]      idx_val,
  output logic [CH_W-1:0]       comp_val
);
  regsel_e sel;
  logic    unused_low;

  // slot select lives in the word-address bits only
  assign sel        = regsel_e'(addr[SEL_LSB +: 2]);
  assign unused_low = ^{addr[SEL_LSB-1:0], wdata[BUS_W-CH_W-1:0], wdata[BUS_W-IDX_W-1:0]};

  always_comb begin
    idx_wr  = 1'b0;
    data_wr = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_INDEX: idx_wr  = 1'b1;
        SEL_DATA:  data_wr = 1'b1;
        default: ;
      endcase
    end
  end

  assign idx_val  = wdata[BUS_W-1 -: IDX_W];
  assign comp_val = wdata[BUS_W-1 -: CH_W];
endmodule

// File: rtl/clut_seq.sv
`timescale 1ns/100ps
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_wr,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] idx_val,
  output logic [IDX_W-1:0] idx_q,
  output phase_e           phase_q,
  output logic [NCH-1:0]   ch_we
);
  localparam logic [IDX_W-1:0] IDX_STEP = IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (idx_wr) begin
      idx_q   <= idx_val;
      phase_q <= PH_RED;
    end else if (data_wr) begin
      unique case (phase_q)
        PH_RED: phase_q <= PH_GRN;
        PH_GRN: phase_q <= PH_BLU;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + IDX_STEP;
        end
      endcase
    end
  end

  // bit 0 = red channel, 1 = green, 2 = blue
  always_comb begin
    ch_we = '0;
    if (data_wr) begin
      unique case (phase_q)
        PH_RED:  ch_we[0] = 1'b1;
        PH_GRN:  ch_we[1] = 1'b1;
        default: ch_we[2] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/clut_store.sv
`timescale 1ns/100ps
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ch_we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [CH_W-1:0]   wval,
  input  logic [IDX_W-1:0]  raddr,
  output logic [NCH*CH_W-1:0] rgb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LAST    = ENTRIES - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int e = 0; e < ENTRIES; e++) begin
          mem[e] <= (e == LAST) ? {CH_W{1'b1}} : '0;
        end
      end else if (ch_we[c]) begin
        mem[waddr] <= wval;
      end
    end

    // channel 0 (red) occupies the most significant field
    assign rgb[(NCH-1-c)*CH_W +: CH_W] = mem[raddr];
  end
endmodule

// File: rtl/clut_dac.sv
`timescale 1ns/100ps
module clut_dac
  import clut_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [WIN_ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]      wdata,
  output logic [BUS_W-1:0]      rdata,
  input  logic [IDX_W-1:0]      lookup_code,
  output logic [NCH*CH_W-1:0]   lookup_rgb
);
  logic             idx_wr;
  logic             data_wr;
  logic [IDX_W-1:0] idx_val;
  logic [CH_W-1:0]  comp_val;
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;
  logic [NCH-1:0]   ch_we;

  clut_decode #(.BUS_W(BUS_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_dec (
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .idx_wr   (idx_wr),
    .data_wr  (data_wr),
    .idx_val  (idx_val),
    .comp_val (comp_val)
  );

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .idx_wr  (idx_wr),
    .data_wr (data_wr),
    .idx_val (idx_val),
    .idx_q   (idx_q),
    .phase_q (phase_q),
    .ch_we   (ch_we)
  );

  clut_store #(.IDX_W(IDX_W), .CH_W(CH_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .ch_we (ch_we),
    .waddr (idx_q),
    .wval  (comp_val),
    .raddr (lookup_code),
    .rgb   (lookup_rgb)
  );

  assign rdata = '0;
endmodule

// File: rtl/clut_dac_chk.sv
`timescale 1ns/100ps
module clut_dac_chk #(
  parameter int BUS_W = 32,
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [3:0]          addr,
  input logic [BUS_W-1:0]    wdata,
  input logic [IDX_W-1:0]    lookup_code,
  input logic [3*CH_W-1:0]   lookup_rgb,
  input logic [IDX_W-1:0]    idx_q,
  input logic [1:0]          phase_q
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] TOP = {IDX_W{1'b1}};

  logic [1:0] sel;
  logic       unused_chk;
  assign sel        = addr[3:2];
  assign unused_chk = ^{addr[1:0], wdata[BUS_W-CH_W-1:0], wdata[BUS_W-IDX_W-1:0]};

  // R1: the last entry reads white in the first cycle after reset
  a_r1_white_after_reset: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lookup_code == TOP) |-> lookup_rgb == {3*CH_W{1'b1}});

  // R3: index slot loads the top byte and restarts at red
  a_r3_index_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 2'd0) |=>
      (idx_q == $past(wdata[BUS_W-1 -: IDX_W]) && phase_q == 2'd0));

  // R4: red and green writes step the phase, entry held
  a_r4_phase_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 2'd1 && phase_q != 2'd2) |=>
      (phase_q == $past(phase_q) + 2'd1 && $stable(idx_q)));

  // R4: phase never reaches the unused encoding
  a_r4_phase_legal: assert property (@(posedge clk) disable iff (rst)
    phase_q != 2'd3);

  // R4: a red write shows up on the lookup port for the same entry
  a_r4_red_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 2'd1 && phase_q == 2'd0 && lookup_code == idx_q) |=>
      (!$stable(lookup_code) ||
       lookup_rgb[3*CH_W-1 -: CH_W] == $past(wdata[BUS_W-1 -: CH_W])));

  // R5: blue write advances the entry and wraps the phase
  a_r5_blue_advance: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 2'd1 && phase_q == 2'd2) |=>
      (idx_q == $past(idx_q) + ONE && phase_q == 2'd0));

  // R6: spare slots leave the sequence untouched
  a_r6_spare_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel[1]) |=> ($stable(idx_q) && $stable(phase_q)));

  // R9: no strobe, no state change
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(idx_q) && $stable(phase_q)));
endmodule

bind clut_dac clut_dac_chk #(.BUS_W(BUS_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .lookup_code (lookup_code),
  .lookup_rgb  (lookup_rgb),
  .idx_q       (idx_q),
  .phase_q     (phase_q)
);

// File: tb/sim_clut_dac.sv
`timescale 1ns/100ps
module sim_clut_dac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  code = '0;
  wire  [31:0] rdata;
  wire  [23:0] rgb;

  always #2 clk = ~clk;

  clut_dac u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lookup_code(code), .lookup_rgb(rgb)
  );

  int n_run = 0;
  int n_fail = 0;
  bit live = 0;
  bit done = 0;

  // behavioural reference
  int m_r[256];
  int m_g[256];
  int m_b[256];
  int m_idx;
  int m_ph;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) begin
        m_r[i] = (i == 255) ? 255 : 0;
        m_g[i] = m_r[i];
        m_b[i] = m_r[i];
      end
      m_idx = 0;
      m_ph  = 0;
      live  = 1;
    end else if (wr_en) begin
      if (addr[3:2] == 2'd0) begin
        m_idx = int'(wdata[31:24]);
        m_ph  = 0;
      end else if (addr[3:2] == 2'd1) begin
        if (m_ph == 0) m_r[m_idx] = int'(wdata[31:24]);
        else if (m_ph == 1) m_g[m_idx] = int'(wdata[31:24]);
        else m_b[m_idx] = int'(wdata[31:24]);
        if (m_ph == 2) begin
          m_ph  = 0;
          m_idx = (m_idx + 1) % 256;
        end else begin
          m_ph = m_ph + 1;
        end
      end
    end
  end

  function automatic logic [31:0] model_rgb(int c);
    return 32'((m_r[c] << 16) | (m_g[c] << 8) | m_b[c]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 lookup path, R7 read data)
  always @(negedge clk) begin
    if (live && !rst && !done) begin
      check("R8 per-cycle lookup", {8'h00, rgb}, model_rgb(int'(code)));
      check("R7 rdata zero", rdata, 32'h0);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    #0.5;
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(posedge clk);
    #0.5;
    wr_en = 1'b0;
  endtask

  task automatic idle_bus(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    #0.5;
    wr_en = 1'b0;
    addr  = a;
    wdata = d;
    @(posedge clk);
    #0.5;
  endtask

  task automatic look(logic [7:0] c, logic [23:0] exp, string req);
    @(negedge clk);
    #0.5;
    code = c;
    #0.5;
    check(req, {8'h00, rgb}, {8'h00, exp});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #0.5;
    rst = 1'b0;

    // R1 reset contents
    look(8'hFF, 24'hFFFFFF, "R1 last entry white");
    look(8'h00, 24'h000000, "R1 entry 0 black");
    look(8'hFE, 24'h000000, "R1 entry 254 black");
    look(8'h80, 24'h000000, "R1 entry 128 black");

    // R4 ordered components, low bytes discarded
    wr(4'h0, 32'h10_00_00_00);
    wr(4'h4, 32'hAA_12_34_56);
    look(8'h10, 24'hAA0000, "R4 red first");
    wr(4'h4, 32'hBB_FF_FF_FF);
    wr(4'h4, 32'hCC_00_00_01);
    look(8'h10, 24'hAABBCC, "R4 full entry");

    // R5 autoincrement
    wr(4'h4, 32'h11_00_00_00);
    wr(4'h4, 32'h22_00_00_00);
    wr(4'h4, 32'h33_00_00_00);
    look(8'h11, 24'h112233, "R5 next entry");
    look(8'h12, 24'h000000, "R5 neighbour untouched");

    // R5 wrap 255 -> 0
    wr(4'h0, 32'hFF_00_00_00);
    wr(4'h4, 32'hDE_00_00_00);
    wr(4'h4, 32'hAD_00_00_00);
    wr(4'h4, 32'hBE_00_00_00);
    look(8'hFF, 24'hDEADBE, "R5 entry 255");
    wr(4'h4, 32'h01_00_00_00);
    wr(4'h4, 32'h02_00_00_00);
    wr(4'h4, 32'h03_00_00_00);
    look(8'h00, 24'h010203, "R5 wrap to 0");

    // R3 index write mid-sequence restarts at red
    wr(4'h0, 32'h20_00_00_00);
    wr(4'h4, 32'h01_00_00_00);
    wr(4'h0, 32'h30_00_00_00);
    wr(4'h4, 32'h44_00_00_00);
    wr(4'h4, 32'h55_00_00_00);
    wr(4'h4, 32'h66_00_00_00);
    look(8'h30, 24'h445566, "R3 restart at red");
    look(8'h20, 24'h010000, "R3 partial entry kept");

    // R2 low address bits ignored
    wr(4'h3, 32'h50_00_00_00);
    wr(4'h5, 32'h61_00_00_00);
    wr(4'h6, 32'h62_00_00_00);
    wr(4'h7, 32'h63_00_00_00);
    look(8'h50, 24'h616263, "R2 addr low bits");

    // R6 spare slots ignored mid-sequence
    wr(4'h0, 32'h40_00_00_00);
    wr(4'h4, 32'h77_00_00_00);
    wr(4'h8, 32'h99_00_00_00);
    wr(4'hC, 32'h41_00_00_00);
    wr(4'h4, 32'h88_00_00_00);
    wr(4'h4, 32'h5A_00_00_00);
    look(8'h40, 24'h77885A, "R6 sequence intact");
    look(8'h41, 24'h000000, "R6 entry not moved");
    look(8'h99, 24'h000000, "R6 no stray store");

    // R9 strobe low
    wr(4'h0, 32'h60_00_00_00);
    wr(4'h4, 32'h10_00_00_00);
    idle_bus(4'h0, 32'h70_00_00_00);
    idle_bus(4'h4, 32'hEE_00_00_00);
    wr(4'h4, 32'h20_00_00_00);
    wr(4'h4, 32'h30_00_00_00);
    look(8'h60, 24'h102030, "R9 idle bus ignored");
    look(8'h70, 24'h000000, "R9 no index load");

    // R8 same-cycle response to code changes
    look(8'h10, 24'hAABBCC, "R8 combinational A");
    look(8'h11, 24'h112233, "R8 combinational B");

    // R7 explicit
    @(negedge clk);
    check("R7 rdata after writes", rdata, 32'h0);

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule